// File: doc/BRIEF.md
# Video Domain Power Sequencer

This block switches a video and display power domain on and off in a fixed order with timed gaps. It drives the main power switch, the output isolation clamp, 72 memory power-down lines, a domain reset and two clock enables. Each sequence starts from a single-cycle command pulse.

The 72 memory lines fall into three groups. Two 32-bit banks are treated as sixteen 2-bit slices each, and only the upper bit of every slice is driven. A third group has 8 bits. All gaps are counted in pulses of a one-microsecond tick input, using one shared down-counter.

A strap input is sampled once after reset and gives the starting state. A `busy` output shows that a sequence is running. A `powered` output shows the settled state of the domain.

Top module: `vpd_pwr_seq`

## Requirements
- R1: The strap value is taken in the first cycle after reset is released. With the strap low the block comes up with: switch open, clamp on, every driven memory bit at 1, domain reset low, both clocks off, powered low. With the strap high it comes up with: switch closed, clamp off, every memory bit 0, both clocks on, powered high.
- R2: A down command raises the isolation clamp first, while the switch and both clocks are still on. The first memory step comes exactly T_SETTLE ticks after the clamp rises.
- R3: The memory lines step in a fixed order. Let s be the step number. Steps 0..15 drive bit 2s+1 of bank A. Steps 16..31 drive bit 2(s-16)+1 of bank B. Steps 32..39 drive bit s-32 of the 8-bit group. Each step changes exactly one bit: to 1 when powering down, to 0 when powering up. Consecutive steps are T_STEP ticks apart.
- R4: On the way down, the switch opens T_STEP+T_SETTLE ticks after the last memory step. Both clocks turn off, and powered falls, in the same cycle, T_DRAIN ticks after the switch opens.
- R5: An up command closes the switch first. The first memory step comes T_SETTLE ticks later. The domain reset rises T_STEP+T_SETTLE ticks after the last memory step.
- R6: On the way up, the actions after the memories run one per cycle: reset rises, then the clamp drops, then reset falls, then the core clock turns on, then the bus clock turns on together with powered.
- R7: The powered output changes only in the cycle that ends a sequence, together with the bus clock enable.
- R8: Any command that arrives while a sequence is running is ignored. The sequence that is running ends in its normal final state.
- R9: An up command while powered, or a down command while unpowered, does nothing. Busy stays low and no output changes.
- R10: The even bit of every 2-bit slice in both banks is always 0.
- R11: Busy rises in the cycle after a command is accepted. It falls in the cycle in which the last action of the sequence appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| pwr_up_cmd_i | input | 1 | Single-cycle power-up command |
| pwr_dn_cmd_i | input | 1 | Single-cycle power-down (or shutdown) command |
| boot_sw_on_i | input | 1 | Strap giving the switch state at start-up |
| pwr_sw_on_o | output | 1 | Power switch closed |
| iso_en_o | output | 1 | Isolation clamp active |
| mem_pd_a_o | output | 2*SLICES | Memory power-down bank A |
| mem_pd_b_o | output | 2*SLICES | Memory power-down bank B |
| mem_pd_c_o | output | GRP_BITS | Memory power-down group |
| dom_rst_o | output | 1 | Domain reset |
| clk_en_core_o | output | 1 | Core clock enable |
| clk_en_bus_o | output | 1 | Bus clock enable |
| busy_o | output | 1 | Sequence in progress |
| powered_o | output | 1 | Domain powered |

## Verification
The bench counts the tick pulses between every pair of output events.

- A timer that is off by one tick, or that counts the tick arriving in its load cycle, shows up as a wrong gap: 4 or 6 where 5 is expected, or 19 or 21 where 20 is expected.
- A walker with a wrong bit mapping, or one that skips a slice or writes the even bits, produces a change that differs from the single expected bit for that step.

The final actions of power-up are checked cycle by cycle. If reset and clamp release are swapped, or the two clocks come on together, the check fails.

Commands sent in the middle of a power-down are checked as well. A design that queues them would restart a sequence after the first one ends. Commands that match the current state must leave busy low.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

  typedef enum logic [4:0] {
    ST_BOOT,
    ST_IDLE,
    ST_DN_ISO,
    ST_DN_ISO_W,
    ST_DN_MEM,
    ST_DN_MEM_W,
    ST_DN_TAIL,
    ST_DN_TAIL_W,
    ST_DN_SW,
    ST_DN_SW_W,
    ST_DN_CLK,
    ST_UP_SW,
    ST_UP_SW_W,
    ST_UP_MEM,
    ST_UP_MEM_W,
    ST_UP_TAIL,
    ST_UP_TAIL_W,
    ST_UP_RST,
    ST_UP_ISO,
    ST_UP_RLS,
    ST_UP_CK0,
    ST_UP_CK1
  } vpd_state_e;

  typedef enum logic [1:0] {
    DLY_SETTLE,
    DLY_STEP,
    DLY_DRAIN
  } vpd_dly_e;

endpackage

// File: rtl/vpd_tick_timer.sv
module vpd_tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             tick_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Load on start; otherwise count one tick down per pulse until zero.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start_i) begin
      cnt_d  = len_i;
      cnt_en = 1'b1;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0) && !start_i;

  AST_TMR_NOT_INSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (len_i != '0)) |=> !expired_o); // R3

  AST_TMR_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !tick_i) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/vpd_mem_walker.sv
module vpd_mem_walker #(
  parameter int SLICES   = 16,
  parameter int GRP_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  step_i,
  input  logic                  step_val_i,
  input  logic                  load_i,
  input  logic                  load_val_i,
  output logic [2*SLICES-1:0]   bank_a_o,
  output logic [2*SLICES-1:0]   bank_b_o,
  output logic [GRP_BITS-1:0]   grp_o,
  output logic                  done_o,
  output logic                  all_set_o
);

  localparam int N_STEPS = 2 * SLICES + GRP_BITS;
  localparam int IDX_W   = $clog2(N_STEPS + 1);

  // One flag per driven memory line, kept in walking order.
  logic [N_STEPS-1:0] hi_q;
  logic [N_STEPS-1:0] hi_d;
  logic               hi_en;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   idx_d;
  logic               idx_en;

  always_comb begin
    hi_d  = hi_q;
    hi_en = load_i || step_i;
    if (load_i) begin
      hi_d = {N_STEPS{load_val_i}};
    end else if (step_i && (idx_q < IDX_W'(N_STEPS))) begin
      hi_d[idx_q] = step_val_i;
    end
  end

  always_comb begin
    idx_d  = idx_q;
    idx_en = clr_i || step_i;
    if (clr_i) begin
      idx_d = '0;
    end else if (step_i) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '1;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  // Upper bit of each slice comes from the walker; the lower bit is tied low.
  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    assign bank_a_o[2*s+1] = hi_q[s];
    assign bank_a_o[2*s]   = 1'b0;
    assign bank_b_o[2*s+1] = hi_q[SLICES+s];
    assign bank_b_o[2*s]   = 1'b0;
  end

  for (genvar g = 0; g < GRP_BITS; g++) begin : g_grp
    assign grp_o[g] = hi_q[2*SLICES+g];
  end

  assign done_o    = (idx_q == IDX_W'(N_STEPS));
  assign all_set_o = &hi_q;

  AST_WALK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (idx_q < IDX_W'(N_STEPS))); // R3

  AST_WALK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> ($countones(hi_q ^ $past(hi_q)) <= 1)); // R3

endmodule

// File: rtl/vpd_pwr_seq.sv
module vpd_pwr_seq
  import vpd_pkg::*;
#(
  parameter int SLICES   = 16,
  parameter int GRP_BITS = 8,
  parameter int T_SETTLE = 20,
  parameter int T_STEP   = 5,
  parameter int T_DRAIN  = 20000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  us_tick_i,
  input  logic                  pwr_up_cmd_i,
  input  logic                  pwr_dn_cmd_i,
  input  logic                  boot_sw_on_i,
  output logic                  pwr_sw_on_o,
  output logic                  iso_en_o,
  output logic [2*SLICES-1:0]   mem_pd_a_o,
  output logic [2*SLICES-1:0]   mem_pd_b_o,
  output logic [GRP_BITS-1:0]   mem_pd_c_o,
  output logic                  dom_rst_o,
  output logic                  clk_en_core_o,
  output logic                  clk_en_bus_o,
  output logic                  busy_o,
  output logic                  powered_o
);

  localparam int CNT_W = $clog2(T_DRAIN + 1);

  vpd_state_e       state_q, state_d;
  logic             sw_q, sw_d;
  logic             iso_q, iso_d;
  logic             rst_q, rst_d;
  logic             ck0_q, ck0_d;
  logic             ck1_q, ck1_d;
  logic             pwr_q, pwr_d;

  logic             tmr_start;
  vpd_dly_e         dly_sel;
  logic [CNT_W-1:0] tmr_len;
  logic             tmr_expired;

  logic             walk_step;
  logic             walk_val;
  logic             walk_clr;
  logic             walk_load;
  logic             walk_done;
  logic             walk_all_set;

  always_comb begin
    case (dly_sel)
      DLY_SETTLE: tmr_len = CNT_W'(T_SETTLE);
      DLY_DRAIN:  tmr_len = CNT_W'(T_DRAIN);
      default:    tmr_len = CNT_W'(T_STEP);
    endcase
  end

  vpd_tick_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (tmr_start),
    .len_i     (tmr_len),
    .tick_i    (us_tick_i),
    .expired_o (tmr_expired)
  );

  vpd_mem_walker #(
    .SLICES   (SLICES),
    .GRP_BITS (GRP_BITS)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (walk_clr),
    .step_i     (walk_step),
    .step_val_i (walk_val),
    .load_i     (walk_load),
    .load_val_i (1'b0),
    .bank_a_o   (mem_pd_a_o),
    .bank_b_o   (mem_pd_b_o),
    .grp_o      (mem_pd_c_o),
    .done_o     (walk_done),
    .all_set_o  (walk_all_set)
  );

  // Next-state and action decode.
  always_comb begin
    state_d   = state_q;
    sw_d      = sw_q;
    iso_d     = iso_q;
    rst_d     = rst_q;
    ck0_d     = ck0_q;
    ck1_d     = ck1_q;
    pwr_d     = pwr_q;
    tmr_start = 1'b0;
    dly_sel   = DLY_STEP;
    walk_step = 1'b0;
    walk_val  = 1'b0;
    walk_clr  = 1'b0;
    walk_load = 1'b0;
    case (state_q)
      ST_BOOT: begin
        state_d = ST_IDLE;
        if (boot_sw_on_i) begin
          sw_d      = 1'b1;
          iso_d     = 1'b0;
          ck0_d     = 1'b1;
          ck1_d     = 1'b1;
          pwr_d     = 1'b1;
          walk_load = 1'b1;
        end
      end
      ST_IDLE: begin
        walk_clr = 1'b1;
        if (pwr_dn_cmd_i && pwr_q) begin
          state_d = ST_DN_ISO;
        end else if (pwr_up_cmd_i && !pwr_q) begin
          state_d = ST_UP_SW;
        end
      end
      ST_DN_ISO: begin
        iso_d     = 1'b1;
        tmr_start = 1'b1;
        dly_sel   = DLY_SETTLE;
        state_d   = ST_DN_ISO_W;
      end
      ST_DN_ISO_W: begin
        if (tmr_expired) state_d = ST_DN_MEM;
      end
      ST_DN_MEM: begin
        walk_step = 1'b1;
        walk_val  = 1'b1;
        tmr_start = 1'b1;
        state_d   = ST_DN_MEM_W;
      end
      ST_DN_MEM_W: begin
        if (tmr_expired) state_d = walk_done ? ST_DN_TAIL : ST_DN_MEM;
      end
      ST_DN_TAIL: begin
        tmr_start = 1'b1;
        dly_sel   = DLY_SETTLE;
        state_d   = ST_DN_TAIL_W;
      end
      ST_DN_TAIL_W: begin
        if (tmr_expired) state_d = ST_DN_SW;
      end
      ST_DN_SW: begin
        sw_d      = 1'b0;
        tmr_start = 1'b1;
        dly_sel   = DLY_DRAIN;
        state_d   = ST_DN_SW_W;
      end
      ST_DN_SW_W: begin
        if (tmr_expired) state_d = ST_DN_CLK;
      end
      ST_DN_CLK: begin
        ck0_d   = 1'b0;
        ck1_d   = 1'b0;
        pwr_d   = 1'b0;
        state_d = ST_IDLE;
      end
      ST_UP_SW: begin
        sw_d      = 1'b1;
        tmr_start = 1'b1;
        dly_sel   = DLY_SETTLE;
        state_d   = ST_UP_SW_W;
      end
      ST_UP_SW_W: begin
        if (tmr_expired) state_d = ST_UP_MEM;
      end
      ST_UP_MEM: begin
        walk_step = 1'b1;
        walk_val  = 1'b0;
        tmr_start = 1'b1;
        state_d   = ST_UP_MEM_W;
      end
      ST_UP_MEM_W: begin
        if (tmr_expired) state_d = walk_done ? ST_UP_TAIL : ST_UP_MEM;
      end
      ST_UP_TAIL: begin
        tmr_start = 1'b1;
        dly_sel   = DLY_SETTLE;
        state_d   = ST_UP_TAIL_W;
      end
      ST_UP_TAIL_W: begin
        if (tmr_expired) state_d = ST_UP_RST;
      end
      ST_UP_RST: begin
        rst_d   = 1'b1;
        state_d = ST_UP_ISO;
      end
      ST_UP_ISO: begin
        iso_d   = 1'b0;
        state_d = ST_UP_RLS;
      end
      ST_UP_RLS: begin
        rst_d   = 1'b0;
        state_d = ST_UP_CK0;
      end
      ST_UP_CK0: begin
        ck0_d   = 1'b1;
        state_d = ST_UP_CK1;
      end
      ST_UP_CK1: begin
        ck1_d   = 1'b1;
        pwr_d   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      sw_q    <= 1'b0;
      iso_q   <= 1'b1;
      rst_q   <= 1'b0;
      ck0_q   <= 1'b0;
      ck1_q   <= 1'b0;
      pwr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sw_q    <= sw_d;
      iso_q   <= iso_d;
      rst_q   <= rst_d;
      ck0_q   <= ck0_d;
      ck1_q   <= ck1_d;
      pwr_q   <= pwr_d;
    end
  end

  assign pwr_sw_on_o   = sw_q;
  assign iso_en_o      = iso_q;
  assign dom_rst_o     = rst_q;
  assign clk_en_core_o = ck0_q;
  assign clk_en_bus_o  = ck1_q;
  assign powered_o     = pwr_q;
  assign busy_o        = (state_q != ST_IDLE);

  AST_SW_OPEN_MEM_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_q |-> walk_all_set); // R4

  AST_ISO_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    walk_step |-> iso_q); // R2

  AST_CLK_ON_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ck0_q) |-> (sw_q && !iso_q && !rst_q)); // R6

  AST_PWR_RISE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_q) |-> (ck0_q && ck1_q && sw_q)); // R7

  AST_PWR_FALL_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_q) |-> (!sw_q && !ck0_q && !ck1_q)); // R7

  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DN_MEM_W && !tmr_expired) |=> (state_q == ST_DN_MEM_W)); // R8

endmodule

// File: tb/vpd_pwr_seq_tb_top.sv
module vpd_pwr_seq_tb_top;

  localparam int SLICES   = 16;
  localparam int GRP_BITS = 8;
  localparam int BANK_W   = 2 * SLICES;
  localparam int N_STEPS  = 2 * SLICES + GRP_BITS;
  localparam int MEM_W    = 2 * BANK_W + GRP_BITS;
  localparam int T_SETTLE = 20;
  localparam int T_STEP   = 5;
  localparam int T_DRAIN  = 50;
  localparam logic [BANK_W-1:0] EVEN_MASK = {SLICES{2'b01}};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick, up_cmd, dn_cmd, boot_on;
  logic sw, iso, drst, ck0, ck1, busy, pwr;
  logic [BANK_W-1:0]   mem_a, mem_b;
  logic [GRP_BITS-1:0] mem_c;
  logic [MEM_W-1:0]    mem_flat;
  assign mem_flat = {mem_c, mem_b, mem_a};

  vpd_pwr_seq #(
    .SLICES   (SLICES),
    .GRP_BITS (GRP_BITS),
    .T_SETTLE (T_SETTLE),
    .T_STEP   (T_STEP),
    .T_DRAIN  (T_DRAIN)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .us_tick_i     (tick),
    .pwr_up_cmd_i  (up_cmd),
    .pwr_dn_cmd_i  (dn_cmd),
    .boot_sw_on_i  (boot_on),
    .pwr_sw_on_o   (sw),
    .iso_en_o      (iso),
    .mem_pd_a_o    (mem_a),
    .mem_pd_b_o    (mem_b),
    .mem_pd_c_o    (mem_c),
    .dom_rst_o     (drst),
    .clk_en_core_o (ck0),
    .clk_en_bus_o  (ck1),
    .busy_o        (busy),
    .powered_o     (pwr)
  );

  int checks = 0;
  int errors = 0;

  bit     mon_en = 1'b0;
  bit     dir_down = 1'b0;
  int     k = 0;
  longint tick_cnt = 0, last_tick = 0, sw_tick = 0, cyc = 0, rst_cyc = 0;
  logic [MEM_W-1:0] prev_mem;
  logic   p_sw, p_iso, p_rst, p_ck0, p_ck1, p_pwr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [MEM_W-1:0] act, input logic [MEM_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int step_pos(input int s);
    if (s < SLICES) return 2 * s + 1;
    else if (s < 2 * SLICES) return BANK_W + 2 * (s - SLICES) + 1;
    else return 2 * BANK_W + (s - 2 * SLICES);
  endfunction

  function automatic logic [MEM_W-1:0] down_vec();
    logic [MEM_W-1:0] v;
    v = '0;
    for (int s = 0; s < N_STEPS; s++) v[step_pos(s)] = 1'b1;
    return v;
  endfunction

  // Event monitor: tick spacing, step order and per-cycle ordering.
  task automatic monitor_step();
    logic [MEM_W-1:0] diff;
    logic [MEM_W-1:0] want;
    int p;
    diff = mem_flat ^ prev_mem;
    if (diff != '0) begin
      p = (k < N_STEPS) ? step_pos(k) : 0;
      want = MEM_W'(1) << p;
      chk(k < N_STEPS && diff == want && mem_flat[p] == dir_down, "R3", "memory step bit", diff, want);
      chk(tick_cnt - last_tick == longint'((k == 0) ? T_SETTLE : T_STEP),
          (k == 0) ? (dir_down ? "R2" : "R5") : "R3", "ticks before memory step",
          MEM_W'(tick_cnt - last_tick), MEM_W'((k == 0) ? T_SETTLE : T_STEP));
      chk(((mem_a | mem_b) & EVEN_MASK) == '0, "R10", "even slice bits",
          MEM_W'((mem_a | mem_b) & EVEN_MASK), '0);
      k++;
      last_tick = tick_cnt;
    end
    if (iso && !p_iso) begin
      chk(dir_down && k == 0 && sw && ck0 && ck1, "R2", "clamp rises first", MEM_W'(k), 0);
      last_tick = tick_cnt;
    end
    if (!sw && p_sw) begin
      chk(dir_down && k == N_STEPS && tick_cnt - last_tick == longint'(T_STEP + T_SETTLE), "R4",
          "switch open delay", MEM_W'(tick_cnt - last_tick), MEM_W'(T_STEP + T_SETTLE));
      sw_tick = tick_cnt;
    end
    if (!ck0 && p_ck0) begin
      chk(!ck1 && !pwr && !busy && tick_cnt - sw_tick == longint'(T_DRAIN), "R4",
          "clock off after drain", MEM_W'(tick_cnt - sw_tick), MEM_W'(T_DRAIN));
    end
    if (sw && !p_sw) begin
      chk(!dir_down && k == 0 && iso && !ck0, "R5", "switch closes first", MEM_W'(k), 0);
      last_tick = tick_cnt;
    end
    if (drst && !p_rst) begin
      chk(k == N_STEPS && iso && tick_cnt - last_tick == longint'(T_STEP + T_SETTLE), "R5",
          "reset rise delay", MEM_W'(tick_cnt - last_tick), MEM_W'(T_STEP + T_SETTLE));
      rst_cyc = cyc;
    end
    if (!iso && p_iso) chk(cyc == rst_cyc + 1 && drst, "R6", "clamp drop cycle", MEM_W'(cyc - rst_cyc), 1);
    if (!drst && p_rst) chk(cyc == rst_cyc + 2 && !iso && !ck0, "R6", "reset fall cycle", MEM_W'(cyc - rst_cyc), 2);
    if (ck0 && !p_ck0) chk(cyc == rst_cyc + 3 && !ck1 && !pwr, "R6", "core clock cycle", MEM_W'(cyc - rst_cyc), 3);
    if (ck1 && !p_ck1) chk(cyc == rst_cyc + 4 && ck0 && pwr && !busy, "R6", "bus clock cycle", MEM_W'(cyc - rst_cyc), 4);
    if (pwr != p_pwr) chk(ck1 != p_ck1, "R7", "powered changes with bus clock", MEM_W'(pwr), MEM_W'(ck1));
  endtask

  // Monitor first, then drive the tick for the next edge.
  initial begin
    int phase;
    phase = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (mon_en) monitor_step();
      prev_mem = mem_flat;
      p_sw = sw; p_iso = iso; p_rst = drst; p_ck0 = ck0; p_ck1 = ck1; p_pwr = pwr;
      phase = (phase + 1) % 4;
      tick = (phase == 0);
      if (tick) tick_cnt++;
    end
  end

  task automatic do_reset(input bit strap);
    mon_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; boot_on = strap; up_cmd = 1'b0; dn_cmd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_off(input string req);
    chk(!sw && iso && !drst && !ck0 && !ck1 && !pwr && !busy, req, "off state controls",
        MEM_W'({sw, iso, drst, ck0, ck1, pwr, busy}), MEM_W'(7'b0100000));
    chk(mem_flat == down_vec(), req, "off state memories", mem_flat, down_vec());
  endtask

  task automatic check_on(input string req);
    chk(sw && !iso && !drst && ck0 && ck1 && pwr && !busy, req, "on state controls",
        MEM_W'({sw, iso, drst, ck0, ck1, pwr, busy}), MEM_W'(7'b1001110));
    chk(mem_flat == '0, req, "on state memories", mem_flat, '0);
  endtask

  task automatic run_cmd(input bit up);
    int guard;
    dir_down = !up; k = 0; mon_en = 1'b1;
    up_cmd = up; dn_cmd = !up;
    @(negedge clk);
    up_cmd = 1'b0; dn_cmd = 1'b0;
    @(negedge clk);
    chk(busy, "R11", "busy after command", MEM_W'(busy), 1);
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(k == N_STEPS, "R3", "memory step count", MEM_W'(k), MEM_W'(N_STEPS));
  endtask

  task automatic t_reset_off();
    do_reset(1'b0);
    check_off("R1");
    chk(((mem_a | mem_b) & EVEN_MASK) == '0, "R10", "even bits after reset",
        MEM_W'((mem_a | mem_b) & EVEN_MASK), '0);
  endtask

  task automatic t_redundant(input bit up);
    logic [MEM_W+6:0] snap;
    bit same;
    snap = {mem_flat, sw, iso, drst, ck0, ck1, pwr, busy};
    same = 1'b1;
    up_cmd = up; dn_cmd = !up;
    @(negedge clk);
    up_cmd = 1'b0; dn_cmd = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if ({mem_flat, sw, iso, drst, ck0, ck1, pwr, busy} != snap) same = 1'b0;
    end
    chk(same, "R9", up ? "up while powered" : "down while unpowered", MEM_W'(same), 1);
  endtask

  task automatic t_power_up();
    run_cmd(1'b1);
    check_on("R6");
  endtask

  task automatic t_down_with_noise();
    int guard;
    dir_down = 1'b1; k = 0; mon_en = 1'b1;
    dn_cmd = 1'b1;
    @(negedge clk);
    dn_cmd = 1'b0;
    repeat (200) @(negedge clk);
    up_cmd = 1'b1;
    @(negedge clk);
    up_cmd = 1'b0;
    repeat (40) @(negedge clk);
    dn_cmd = 1'b1;
    @(negedge clk);
    dn_cmd = 1'b0;
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(k == N_STEPS, "R8", "single walk despite commands", MEM_W'(k), MEM_W'(N_STEPS));
    check_off("R4");
    repeat (10) @(negedge clk);
    chk(!busy && !pwr && !sw, "R8", "no queued command", MEM_W'({busy, pwr, sw}), 0);
  endtask

  task automatic t_boot_on();
    do_reset(1'b1);
    check_on("R1");
    run_cmd(1'b0);
    check_off("R4");
  endtask

  initial begin
    rst_n = 1'b0; up_cmd = 1'b0; dn_cmd = 1'b0; boot_on = 1'b0;
    t_reset_off();
    t_redundant(1'b0);
    t_power_up();
    t_redundant(1'b1);
    t_down_with_noise();
    t_boot_on();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog expired actual=%0d expected=0", busy);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule